// File: doc/BRIEF.md
# ATA Packet Device Register Interface

This block is the device-side register interface of an ATA packet drive. The host drives two active-low chip selects, a 3-bit register address and separate active-low read and write strobes. One chip select opens the command register block and the other opens the control register block. The data register carries 16-bit words through a pair of 16-entry FIFOs, one for each direction. The other registers are byte wide and use the low byte of the 16-bit bus. The block also runs the DMA request/acknowledge handshake. It drives a 16-bit-capable indication, a ready output and a host interrupt request.

On the local side, an internal controller reads and writes the byte registers through a simple select/write port. It fills the host-bound FIFO and drains the host-written FIFO through push/pop ports. It arms DMA in either direction and raises the host interrupt. When the host writes a command, a one-cycle local interrupt pulse is produced. When that command is the soft-reset opcode, a one-cycle reset event pulse is also produced, so that other logic can restart the local CPU.

All host inputs are treated as synchronous to `clk`. Each strobe assertion performs exactly one access. A data-register access that cannot complete yet holds the ready output low until the FIFO allows it.

Top module: `hostRegIf`

## Requirements
- R1: With `cmdCsN` low, addresses 1 to 6 are byte registers. A host write stores `hostDataIn[7:0]`, and a host read returns the byte with bits 15:8 zero. The local port reads the same byte at `locRegSel` equal to the address. If the host and the local port write the same byte in one cycle, the host value is kept.
- R2: Command-block address 0 is the 16-bit data register. Host writes enter the host-written FIFO, and host reads take words from the host-bound FIFO. Each FIFO holds 16 words and keeps first-in first-out order.
- R3: A host read of command-block address 7 returns the status byte written locally at `locRegSel` 7. A read of control-block address 6 returns the same byte. A host write to command address 7 stores the command byte, which the local port reads at `locRegSel` 7. A write to control address 6 stores a device-control byte, read locally at `locRegSel` 0. Other control-block addresses read as zero.
- R4: One strobe assertion performs one access however long it is held. A strobe with neither chip select low and DMA acknowledge high has no effect.
- R5: `wideOk` is high only while `cmdCsN` is low, `ctlCsN` is high, the address is 0 and `dmaAckN` is high. It is never high while `dmaAckN` is low.
- R6: `ioReady` is low while a data-register read waits on an empty host-bound FIFO, or a data-register write waits on a full host-written FIFO. Otherwise it is high. The waiting access completes once a word or a free slot appears.
- R7: A host write of 08h to the command register gives a one-cycle pulse on both `softRst` and `locIrq`, in the cycle after the write is taken. Any other command value pulses `locIrq` only.
- R8: `locIrqSet` sets `hostIrq`. A host read of command address 7 clears it, and a read of control address 6 does not. When a set and a clear come in the same cycle, the set wins.
- R9: `dmaReq` is high when `dmaArm` is high and the selected FIFO can move data. With `dmaToHost` at 1 that means the host-bound FIFO is not empty. With `dmaToHost` at 0 it means the host-written FIFO is not full. While `dmaAckN` is low, strobes reach only the data FIFOs, whatever the chip selects and address are.
- R10: `locPushReady` is low when the host-bound FIFO is full, and a push made then is dropped. `locPopValid` is high when the host-written FIFO holds a word, and `locPopData` shows its oldest word.
- R11: After reset both FIFOs are empty, all byte registers and `hostDataOut` are zero, `hostIrq`, `softRst`, `locIrq` and `dmaReq` are low, and `ioReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdCsN | input | 1 | Host select for the command register block, active low |
| ctlCsN | input | 1 | Host select for the control register block, active low |
| hostAddr | input | 3 | Host register address |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostDataIn | input | 16 | Host write data |
| hostDataOut | output | 16 | Host read data, captured when the read is taken |
| dmaAckN | input | 1 | Host DMA acknowledge, active low |
| dmaReq | output | 1 | DMA request to the host |
| wideOk | output | 1 | Current access may use the full 16-bit width |
| ioReady | output | 1 | Low while a data access is waiting |
| hostIrq | output | 1 | Interrupt request to the host |
| locRegSel | input | 3 | Local register select |
| locRegWe | input | 1 | Local register write enable |
| locRegWdata | input | 8 | Local register write data |
| locRegData | output | 8 | Local register read data |
| locPushEn | input | 1 | Push a word into the host-bound FIFO |
| locPushData | input | 16 | Word to push |
| locPushReady | output | 1 | Host-bound FIFO has a free slot |
| locPopEn | input | 1 | Pop a word from the host-written FIFO |
| locPopData | output | 16 | Oldest word of the host-written FIFO |
| locPopValid | output | 1 | Host-written FIFO is not empty |
| dmaArm | input | 1 | Enable the DMA request |
| dmaToHost | input | 1 | DMA direction, 1 means device to host |
| locIrqSet | input | 1 | Set the host interrupt |
| softRst | output | 1 | One-cycle soft-reset event |
| locIrq | output | 1 | One-cycle pulse on each host command write |

## Verification
A vector table first mixes host writes and reads across the byte registers of both blocks. It checks that upper bytes are dropped, that unused control addresses read as zero, and that unwritten registers stay zero. This separates correct address decoding from aliasing. Directed sequences then fill the host-bound FIFO to 16 words and drain it, and fill the host-written FIFO and stall one more write. This separates FIFO ordering and full/empty handling from the ready stall. Further sequences hold a strobe for several cycles, strobe without a select, run DMA in both directions with a misleading address, and issue 08h against another command code. Together these distinguish one-access-per-strobe, DMA steering, and reset-event decoding from plain command capture.

// File: rtl/hostRegPkg.sv
package hostRegPkg;

  localparam int ADDR_W    = 3;
  localparam int BYTE_W    = 8;
  localparam int DATA_ADDR = 0;
  localparam int TF_FIRST  = 1;
  localparam int TF_LAST   = 6;
  localparam int ALT_ADDR  = 6;
  localparam int STAT_ADDR = 7;
  localparam int NUM_REG   = 1 << ADDR_W;
  localparam logic [BYTE_W-1:0] SRST_CODE = 8'h08;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_FIFO,
    SRC_TF,
    SRC_STAT
  } rdSrc_e;

  typedef struct packed {
    logic   rdLatch;
    rdSrc_e rdSrc;
    logic   txPop;
    logic   rxPush;
    logic   tfWrite;
    logic   cmdWrite;
    logic   ctlWrite;
    logic   irqClear;
  } hostStrb_t;

endpackage

// File: rtl/hostRegFifo.sv
module hostRegFifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10: a push into a full FIFO leaves the fill level alone
  a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> $stable(count));

  // R2: the fill level never passes the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

endmodule

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdCsN,
  input  logic              ctlCsN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              dmaAckN,
  input  logic              txEmpty,
  input  logic              rxFull,
  output hostStrb_t         strb,
  output logic              ioReady,
  output logic              wideOk
);

  logic dmaAct, cmdSel, ctlSel, anySel, dataSel, isTf, isStat, isAlt;
  logic rdDone, wrDone, rdReq, wrReq, rdStall, wrStall, rdGo, wrGo;

  assign dmaAct  = !dmaAckN;
  assign cmdSel  = !cmdCsN && ctlCsN && !dmaAct;
  assign ctlSel  = !ctlCsN && cmdCsN && !dmaAct;
  assign anySel  = cmdSel || ctlSel || dmaAct;
  assign dataSel = dmaAct || (cmdSel && hostAddr == ADDR_W'(DATA_ADDR));
  assign isTf    = hostAddr >= ADDR_W'(TF_FIRST) && hostAddr <= ADDR_W'(TF_LAST);
  assign isStat  = hostAddr == ADDR_W'(STAT_ADDR);
  assign isAlt   = hostAddr == ADDR_W'(ALT_ADDR);

  assign rdReq   = !hostRdN && anySel && !rdDone;
  assign wrReq   = !hostWrN && anySel && !wrDone;
  assign rdStall = rdReq && dataSel && txEmpty;
  assign wrStall = wrReq && dataSel && rxFull;
  assign rdGo    = rdReq && !rdStall;
  assign wrGo    = wrReq && !wrStall;

  assign ioReady = !(rdStall || wrStall);
  assign wideOk  = cmdSel && hostAddr == ADDR_W'(DATA_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDone <= 1'b0;
      wrDone <= 1'b0;
    end else begin
      if (hostRdN)   rdDone <= 1'b0;
      else if (rdGo) rdDone <= 1'b1;
      if (hostWrN)   wrDone <= 1'b0;
      else if (wrGo) wrDone <= 1'b1;
    end
  end

  always_comb begin
    strb.rdLatch  = rdGo;
    strb.rdSrc    = SRC_ZERO;
    strb.txPop    = 1'b0;
    strb.rxPush   = 1'b0;
    strb.tfWrite  = 1'b0;
    strb.cmdWrite = 1'b0;
    strb.ctlWrite = 1'b0;
    strb.irqClear = 1'b0;
    if (rdGo) begin
      if (dataSel) begin
        strb.rdSrc = SRC_FIFO;
        strb.txPop = 1'b1;
      end else if (cmdSel && isTf) begin
        strb.rdSrc = SRC_TF;
      end else if (cmdSel && isStat) begin
        strb.rdSrc    = SRC_STAT;
        strb.irqClear = 1'b1;
      end else if (ctlSel && isAlt) begin
        strb.rdSrc = SRC_STAT;
      end
    end
    if (wrGo) begin
      if (dataSel)               strb.rxPush   = 1'b1;
      else if (cmdSel && isTf)   strb.tfWrite  = 1'b1;
      else if (cmdSel && isStat) strb.cmdWrite = 1'b1;
      else if (ctlSel && isAlt)  strb.ctlWrite = 1'b1;
    end
  end

  // R4: a held read strobe is served once
  a_r4_single_read: assert property (@(posedge clk) disable iff (!rstN)
    rdGo |=> !rdGo);

  // R4: a held write strobe is served once
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rstN)
    wrGo |=> !wrGo);

  // R9: during DMA acknowledge no byte register is written
  a_r9_dma_data_only: assert property (@(posedge clk) disable iff (!rstN)
    dmaAct |-> !(strb.tfWrite || strb.cmdWrite || strb.ctlWrite));

endmodule

// File: rtl/hostRegDpath.sv
module hostRegDpath
  import hostRegPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrb_t         strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostIrq,
  input  logic [ADDR_W-1:0] locRegSel,
  input  logic              locRegWe,
  input  logic [BYTE_W-1:0] locRegWdata,
  output logic [BYTE_W-1:0] locRegData,
  input  logic              locPushEn,
  input  logic [DATA_W-1:0] locPushData,
  output logic              locPushReady,
  input  logic              locPopEn,
  output logic [DATA_W-1:0] locPopData,
  output logic              locPopValid,
  input  logic              dmaArm,
  input  logic              dmaToHost,
  input  logic              locIrqSet,
  output logic              dmaReq,
  output logic              softRst,
  output logic              locIrq,
  output logic              txEmpty,
  output logic              rxFull
);

  localparam int PAD_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] tfReg [NUM_REG];
  logic [BYTE_W-1:0] statReg, cmdReg, devCtl;
  logic [DATA_W-1:0] txHead, rdMux;
  logic              txFull, rxEmpty;
  logic [BYTE_W-1:0] hostByte;

  assign hostByte = hostDataIn[BYTE_W-1:0];

  hostRegFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) txFifo_i (
    .clk(clk), .rstN(rstN),
    .push(locPushEn), .pushData(locPushData),
    .pop(strb.txPop), .head(txHead),
    .full(txFull), .empty(txEmpty)
  );

  hostRegFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rxFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strb.rxPush), .pushData(hostDataIn),
    .pop(locPopEn), .head(locPopData),
    .full(rxFull), .empty(rxEmpty)
  );

  assign locPushReady = !txFull;
  assign locPopValid  = !rxEmpty;
  assign dmaReq       = dmaArm && (dmaToHost ? !txEmpty : !rxFull);

  generate
    for (genvar i = 0; i < NUM_REG; i++) begin : g_tf
      if (i >= TF_FIRST && i <= TF_LAST) begin : g_live
        always_ff @(posedge clk) begin
          if (!rstN)
            tfReg[i] <= '0;
          else if (strb.tfWrite && hostAddr == ADDR_W'(i))
            tfReg[i] <= hostByte;
          else if (locRegWe && locRegSel == ADDR_W'(i))
            tfReg[i] <= locRegWdata;
        end
      end else begin : g_none
        assign tfReg[i] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
      cmdReg  <= '0;
      devCtl  <= '0;
      hostIrq <= 1'b0;
      softRst <= 1'b0;
      locIrq  <= 1'b0;
    end else begin
      if (locRegWe && locRegSel == ADDR_W'(STAT_ADDR)) statReg <= locRegWdata;
      if (strb.cmdWrite) cmdReg <= hostByte;
      if (strb.ctlWrite) devCtl <= hostByte;
      if (locIrqSet)          hostIrq <= 1'b1;
      else if (strb.irqClear) hostIrq <= 1'b0;
      softRst <= strb.cmdWrite && hostByte == SRST_CODE;
      locIrq  <= strb.cmdWrite;
    end
  end

  always_comb begin
    case (strb.rdSrc)
      SRC_FIFO: rdMux = txHead;
      SRC_TF:   rdMux = {{PAD_W{1'b0}}, tfReg[hostAddr]};
      SRC_STAT: rdMux = {{PAD_W{1'b0}}, statReg};
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             hostDataOut <= '0;
    else if (strb.rdLatch) hostDataOut <= rdMux;
  end

  always_comb begin
    if (locRegSel == ADDR_W'(DATA_ADDR))      locRegData = devCtl;
    else if (locRegSel == ADDR_W'(STAT_ADDR)) locRegData = cmdReg;
    else                                      locRegData = tfReg[locRegSel];
  end

  // R8: a status read with no set in the same cycle drops the host interrupt
  a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.irqClear && !locIrqSet) |=> !hostIrq);

  // R7: the soft-reset event lasts one cycle
  a_r7_srst_pulse: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !softRst);

  // R7: every soft-reset event comes with a local interrupt
  a_r7_srst_with_irq: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> locIrq);

endmodule

// File: rtl/hostRegIf.sv
module hostRegIf
  import hostRegPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdCsN,
  input  logic              ctlCsN,
  input  logic [2:0]        hostAddr,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  input  logic              dmaAckN,
  output logic              dmaReq,
  output logic              wideOk,
  output logic              ioReady,
  output logic              hostIrq,
  input  logic [2:0]        locRegSel,
  input  logic              locRegWe,
  input  logic [7:0]        locRegWdata,
  output logic [7:0]        locRegData,
  input  logic              locPushEn,
  input  logic [DATA_W-1:0] locPushData,
  output logic              locPushReady,
  input  logic              locPopEn,
  output logic [DATA_W-1:0] locPopData,
  output logic              locPopValid,
  input  logic              dmaArm,
  input  logic              dmaToHost,
  input  logic              locIrqSet,
  output logic              softRst,
  output logic              locIrq
);

  hostStrb_t strb;
  logic      txEmpty, rxFull;

  hostRegCtrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdCsN(cmdCsN), .ctlCsN(ctlCsN), .hostAddr(hostAddr),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .dmaAckN(dmaAckN),
    .txEmpty(txEmpty), .rxFull(rxFull),
    .strb(strb), .ioReady(ioReady), .wideOk(wideOk)
  );

  hostRegDpath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(hostAddr),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostIrq(hostIrq),
    .locRegSel(locRegSel), .locRegWe(locRegWe), .locRegWdata(locRegWdata),
    .locRegData(locRegData),
    .locPushEn(locPushEn), .locPushData(locPushData), .locPushReady(locPushReady),
    .locPopEn(locPopEn), .locPopData(locPopData), .locPopValid(locPopValid),
    .dmaArm(dmaArm), .dmaToHost(dmaToHost), .locIrqSet(locIrqSet),
    .dmaReq(dmaReq), .softRst(softRst), .locIrq(locIrq),
    .txEmpty(txEmpty), .rxFull(rxFull)
  );

endmodule

// File: tb/hostRegIf_tb_top.sv
module hostRegIf_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdCsN = 1'b1, ctlCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1, dmaAckN = 1'b1;
  logic [2:0]  hostAddr = '0, locRegSel = '0;
  logic [15:0] hostDataIn = '0, locPushData = '0;
  logic [7:0]  locRegWdata = '0;
  logic        locRegWe = 0, locPushEn = 0, locPopEn = 0, dmaArm = 0, dmaToHost = 0, locIrqSet = 0;
  logic [15:0] hostDataOut, locPopData;
  logic [7:0]  locRegData;
  logic        dmaReq, wideOk, ioReady, hostIrq, locPushReady, locPopValid, softRst, locIrq;

  int          checks = 0;
  int          fails = 0;
  logic [15:0] lastRd;
  logic        seenSrst, seenLirq;
  logic [15:0] tmp;
  logic [7:0]  tmpB;

  always #2 clk = ~clk;

  hostRegIf dut_i (
    .clk(clk), .rstN(rstN), .cmdCsN(cmdCsN), .ctlCsN(ctlCsN), .hostAddr(hostAddr),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .hostDataIn(hostDataIn), .hostDataOut(hostDataOut),
    .dmaAckN(dmaAckN), .dmaReq(dmaReq), .wideOk(wideOk), .ioReady(ioReady), .hostIrq(hostIrq),
    .locRegSel(locRegSel), .locRegWe(locRegWe), .locRegWdata(locRegWdata), .locRegData(locRegData),
    .locPushEn(locPushEn), .locPushData(locPushData), .locPushReady(locPushReady),
    .locPopEn(locPopEn), .locPopData(locPopData), .locPopValid(locPopValid),
    .dmaArm(dmaArm), .dmaToHost(dmaToHost), .locIrqSet(locIrqSet),
    .softRst(softRst), .locIrq(locIrq)
  );

  typedef struct packed {
    logic        isWr;
    logic [1:0]  sel;   // 0 none, 1 command block, 2 control block
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [15:0] expd;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd1, 3'd1, 16'h00A5, 16'h0000},
    '{1'b1, 2'd1, 3'd2, 16'h1234, 16'h0000},
    '{1'b1, 2'd1, 3'd6, 16'h00E0, 16'h0000},
    '{1'b0, 2'd1, 3'd1, 16'h0000, 16'h00A5},
    '{1'b0, 2'd1, 3'd2, 16'h0000, 16'h0034},
    '{1'b0, 2'd1, 3'd6, 16'h0000, 16'h00E0},
    '{1'b0, 2'd2, 3'd3, 16'h0000, 16'h0000},
    '{1'b1, 2'd2, 3'd6, 16'h0002, 16'h0000},
    '{1'b0, 2'd1, 3'd3, 16'h0000, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expd);
    checks++;
    if (act !== expd) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expd);
    end
  endtask

  task automatic hostStart(input logic isWr, input logic [1:0] sel, input logic [2:0] a,
                           input logic [15:0] d);
    @(negedge clk);
    hostAddr = a;
    hostDataIn = d;
    cmdCsN = (sel != 2'd1);
    ctlCsN = (sel != 2'd2);
    if (isWr) hostWrN = 1'b0;
    else      hostRdN = 1'b0;
  endtask

  task automatic hostFinish(input int hold);
    #1;
    while (!ioReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    lastRd = hostDataOut;
    seenSrst = softRst;
    seenLirq = locIrq;
    repeat (hold) @(negedge clk);
    hostRdN = 1'b1;
    hostWrN = 1'b1;
    cmdCsN = 1'b1;
    ctlCsN = 1'b1;
  endtask

  task automatic hostAccess(input logic isWr, input logic [1:0] sel, input logic [2:0] a,
                            input logic [15:0] d);
    hostStart(isWr, sel, a, d);
    hostFinish(0);
  endtask

  task automatic locPush(input logic [15:0] d);
    @(negedge clk);
    locPushEn = 1'b1;
    locPushData = d;
    @(negedge clk);
    locPushEn = 1'b0;
  endtask

  task automatic locPop(output logic [15:0] d);
    @(negedge clk);
    d = locPopData;
    locPopEn = 1'b1;
    @(negedge clk);
    locPopEn = 1'b0;
  endtask

  task automatic locRead(input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk);
    locRegSel = sel;
    #1 d = locRegData;
  endtask

  task automatic locWrite(input logic [2:0] sel, input logic [7:0] d, input logic irq);
    @(negedge clk);
    locRegWe = 1'b1;
    locRegSel = sel;
    locRegWdata = d;
    locIrqSet = irq;
    @(negedge clk);
    locRegWe = 1'b0;
    locIrqSet = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    dmaArm = 1'b1;
    dmaToHost = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R11 reset state
    chk("R11 ioReady", 16'(ioReady), 16'h1);
    chk("R11 hostIrq", 16'(hostIrq), 16'h0);
    chk("R11 dmaReq", 16'(dmaReq), 16'h0);
    chk("R11 hostDataOut", hostDataOut, 16'h0);
    chk("R11 softRst/locIrq", {softRst, locIrq}, 16'h0);
    chk("R11 fifo flags", {locPushReady, locPopValid}, 16'h2);
    dmaArm = 1'b0;

    // R1 R3: vector table over the byte registers
    for (int i = 0; i < NVEC; i++) begin
      hostAccess(VEC[i].isWr, VEC[i].sel, VEC[i].addr, VEC[i].wdata);
      if (!VEC[i].isWr) chk("R1 R3 table read", lastRd, VEC[i].expd);
    end
    locRead(3'd1, tmpB); chk("R1 local view reg1", 16'(tmpB), 16'h00A5);
    locRead(3'd2, tmpB); chk("R1 local view reg2", 16'(tmpB), 16'h0034);
    locRead(3'd0, tmpB); chk("R3 device control", 16'(tmpB), 16'h0002);

    // R1: host and local write same byte in one cycle, host kept
    hostStart(1'b1, 2'd1, 3'd4, 16'h0077);
    locRegWe = 1'b1; locRegSel = 3'd4; locRegWdata = 8'h11;
    hostFinish(0);
    locRegWe = 1'b0;
    locRead(3'd4, tmpB); chk("R1 host wins collision", 16'(tmpB), 16'h0077);

    // R5 wide indication
    @(negedge clk); cmdCsN = 1'b0; hostAddr = 3'd0; #1 chk("R5 wide at data", 16'(wideOk), 16'h1);
    @(negedge clk); hostAddr = 3'd1; #1 chk("R5 narrow at reg1", 16'(wideOk), 16'h0);
    @(negedge clk); hostAddr = 3'd0; dmaAckN = 1'b0; #1 chk("R5 none in DMA", 16'(wideOk), 16'h0);
    @(negedge clk); dmaAckN = 1'b1; cmdCsN = 1'b1; ctlCsN = 1'b0; #1 chk("R5 narrow ctl", 16'(wideOk), 16'h0);
    ctlCsN = 1'b1;

    // R8 R3 status and host interrupt
    locWrite(3'd7, 8'h58, 1'b1);
    chk("R8 irq set", 16'(hostIrq), 16'h1);
    hostAccess(1'b0, 2'd2, 3'd6, 16'h0);
    chk("R3 alt status", lastRd, 16'h0058);
    chk("R8 alt read keeps irq", 16'(hostIrq), 16'h1);
    hostAccess(1'b0, 2'd1, 3'd7, 16'h0);
    chk("R3 status", lastRd, 16'h0058);
    chk("R8 status read clears", 16'(hostIrq), 16'h0);
    hostStart(1'b0, 2'd1, 3'd7, 16'h0);
    locIrqSet = 1'b1;
    hostFinish(0);
    locIrqSet = 1'b0;
    chk("R8 set wins", 16'(hostIrq), 16'h1);

    // R7 commands
    hostAccess(1'b1, 2'd1, 3'd7, 16'h0008);
    chk("R7 srst pulse", 16'(seenSrst), 16'h1);
    chk("R7 local irq", 16'(seenLirq), 16'h1);
    @(negedge clk); chk("R7 pulse ends", {softRst, locIrq}, 16'h0);
    locRead(3'd7, tmpB); chk("R3 command byte", 16'(tmpB), 16'h0008);
    hostAccess(1'b1, 2'd1, 3'd7, 16'h00A0);
    chk("R7 other cmd no srst", 16'(seenSrst), 16'h0);
    chk("R7 other cmd irq", 16'(seenLirq), 16'h1);

    // R10 R2 host-bound FIFO fill and drain
    for (int i = 0; i < 16; i++) locPush(16'hC000 + 16'(i));
    #1 chk("R10 push ready low when full", 16'(locPushReady), 16'h0);
    locPush(16'hDEAD);
    for (int i = 0; i < 16; i++) begin
      hostAccess(1'b0, 2'd1, 3'd0, 16'h0);
      chk("R2 read order", lastRd, 16'hC000 + 16'(i));
    end
    // R6 read stall on empty
    hostStart(1'b0, 2'd1, 3'd0, 16'h0);
    #1 chk("R6 read stall", 16'(ioReady), 16'h0);
    @(negedge clk); #1 chk("R6 read still stalled", 16'(ioReady), 16'h0);
    locPush(16'hBEEF);
    hostFinish(0);
    chk("R6 R10 stalled read completes, drop kept out", lastRd, 16'hBEEF);

    // R2 R6 host-written FIFO fill and write stall
    for (int i = 0; i < 16; i++) hostAccess(1'b1, 2'd1, 3'd0, 16'h7000 + 16'(i));
    hostStart(1'b1, 2'd1, 3'd0, 16'h7FFF);
    #1 chk("R6 write stall", 16'(ioReady), 16'h0);
    locPop(tmp); chk("R10 pop head", tmp, 16'h7000);
    hostFinish(0);
    for (int i = 1; i < 16; i++) begin
      locPop(tmp); chk("R2 write order", tmp, 16'h7000 + 16'(i));
    end
    locPop(tmp); chk("R6 stalled write landed", tmp, 16'h7FFF);
    #1 chk("R10 pop valid low", 16'(locPopValid), 16'h0);

    // R4 held strobe and stray strobe
    locPush(16'h1111);
    locPush(16'h2222);
    hostStart(1'b0, 2'd1, 3'd0, 16'h0);
    hostFinish(3);
    chk("R4 held read", lastRd, 16'h1111);
    hostAccess(1'b0, 2'd1, 3'd0, 16'h0);
    chk("R4 one pop per strobe", lastRd, 16'h2222);
    locPush(16'h3333);
    hostAccess(1'b0, 2'd0, 3'd0, 16'h0);
    hostAccess(1'b1, 2'd0, 3'd1, 16'h0099);
    hostAccess(1'b0, 2'd1, 3'd0, 16'h0);
    chk("R4 no select no pop", lastRd, 16'h3333);
    locRead(3'd1, tmpB); chk("R4 no select no write", 16'(tmpB), 16'h00A5);

    // R9 DMA
    @(negedge clk); dmaArm = 1'b1; dmaToHost = 1'b1;
    #1 chk("R9 no req empty", 16'(dmaReq), 16'h0);
    locPush(16'h4444);
    #1 chk("R9 req to host", 16'(dmaReq), 16'h1);
    @(negedge clk); dmaAckN = 1'b0;
    hostAccess(1'b0, 2'd0, 3'd5, 16'h0);
    chk("R9 DMA read", lastRd, 16'h4444);
    #1 chk("R9 req drops", 16'(dmaReq), 16'h0);
    dmaToHost = 1'b0;
    #1 chk("R9 req from host", 16'(dmaReq), 16'h1);
    hostAccess(1'b1, 2'd0, 3'd3, 16'h5555);
    locPop(tmp); chk("R9 DMA write", tmp, 16'h5555);
    locRead(3'd3, tmpB); chk("R9 addr ignored in DMA", 16'(tmpB), 16'h0000);
    @(negedge clk); dmaAckN = 1'b1; dmaArm = 1'b0;

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule